// File: doc/BRIEF.md
# Spread-Spectrum Sweep Profile Generator

This block produces the signed frequency-offset word that steers a synthesizer's feedback divider so the output clock spreads its energy over a small band below the nominal frequency. The offset stays at or below zero, so the spread is downward only. It changes only at step boundaries. A prescaler divides the reference clock into unit ticks. A step boundary falls after a programmed number of units.

Two sweep shapes are available. The pendulum shape descends by the programmed down step until it reaches a lower limit. It then climbs by the programmed up step back to zero and repeats. The original shape only descends and jumps back to zero one step after reaching the limit, which gives a saw-tooth. The down step is programmed as a 4-bit two's-complement negative number. A one-cycle strobe marks every change of the offset so the divider logic can reload. When spreading is disabled, the offset returns to zero at the next boundary.

Top module: `ssm_profile_gen`

## Requirements
- R1: After reset, `offset` is 0 and `stepStrobe` is 0. The sweep direction is descending, and the prescaler and dwell counters are at zero.
- R2: A unit tick occurs on every PRESCALE-th clock, with a default of 4. A step boundary occurs on a tick once the dwell counter, which advances by one per tick, has reached `dwellUnits`. The dwell counter then restarts at 0, so consecutive boundaries lie (dwellUnits+1)*PRESCALE clocks apart. `offset` changes only at a boundary.
- R3: The down-step magnitude is (16 - downCode) mod 16. So 4'b1111 gives 1, 4'b1110 gives 2, 4'b1001 gives 7, 4'b1000 gives 8 and 4'b0000 gives 0. The up step `upStep` is unsigned.
- R4: With `pendulum` = 1 and `enable` = 1, a descending boundary subtracts the down magnitude and clamps at -LIMIT, which defaults to 16. Reaching -LIMIT turns the sweep to ascending. An ascending boundary adds `upStep` and clamps at 0, and reaching 0 turns the sweep back to descending.
- R5: With `pendulum` = 0 and `enable` = 1, each boundary subtracts the down magnitude and clamps at -LIMIT. The boundary that finds `offset` at -LIMIT sets it to 0. No other increase occurs.
- R6: `offset` always lies between -LIMIT and 0 inclusive.
- R7: With `enable` = 0, each boundary sets `offset` to 0 and the direction to descending. Between boundaries the value is held.
- R8: `stepStrobe` is high for exactly the one clock in which `offset` first shows a new value. It stays low when a boundary leaves the value unchanged.
- R9: In the original shape, `upStep` has no effect on `offset`.
- R10: Selecting the original shape forces the direction to descending. When the pendulum shape is selected again, the sweep descends from the current offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Spreading on when 1 |
| pendulum | input | 1 | 1: pendulum sweep, 0: original saw-tooth |
| upStep | input | 4 | Unsigned ascending step |
| downCode | input | 4 | Descending step, two's-complement negative code |
| dwellUnits | input | 6 | Units per step minus one |
| offset | output | OFS_W (8) | Signed frequency offset |
| stepStrobe | output | 1 | One-clock pulse when offset changes |

## Verification
A behavioural model of the prescaler, the dwell count and the sweep rules runs in the bench on the same rising edge as the design. A boundary detected at edge k is therefore visible on `offset` and `stepStrobe` in the half cycle after edge k, with exactly one register stage on the path. The bench drives inputs on falling edges and compares both outputs with the model at every falling edge. Each compare carries the tag of the requirement under stimulus. Directed checks also measure the spacing between strobes for a dwell setting, the depth the sweep reaches and the value that follows a disable.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_DOWN  = 2'd1,
    OP_UP    = 2'd2,
    OP_CLEAR = 2'd3
  } stepOp_e;

  typedef struct packed {
    logic    apply;
    stepOp_e op;
  } stepCtl_t;
endpackage

// File: rtl/ssm_ctrl.sv
module ssm_ctrl
  import ssm_pkg::*;
#(
  parameter int PRESCALE = 4,
  parameter int DWELL_W  = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               pendulum,
  input  logic [DWELL_W-1:0] dwellUnits,
  input  logic               floorHit,
  input  logic               zeroHit,
  input  logic               atFloor,
  output stepCtl_t           ctl
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic               tick;
  logic               boundary;
  logic [DWELL_W-1:0] dwellCnt;
  logic               dirUp;
  logic               dirUpNext;

  generate
    if (PRESCALE > 1) begin : g_pre
      logic [PRE_W-1:0] preCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) preCnt <= '0;
        else if (preCnt == PRE_W'(PRESCALE - 1)) preCnt <= '0;
        else preCnt <= preCnt + 1'b1;
      end
      assign tick = (preCnt == PRE_W'(PRESCALE - 1));
    end else begin : g_nopre
      assign tick = 1'b1;
    end
  endgenerate

  assign boundary = tick && (dwellCnt >= dwellUnits);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dwellCnt <= '0;
    else if (boundary) dwellCnt <= '0;
    else if (tick) dwellCnt <= dwellCnt + 1'b1;
  end

  always_comb begin
    ctl.apply = boundary;
    ctl.op    = OP_HOLD;
    dirUpNext = dirUp;
    if (boundary) begin
      if (!enable) begin
        ctl.op    = OP_CLEAR;
        dirUpNext = 1'b0;
      end else if (!pendulum) begin
        ctl.op    = atFloor ? OP_CLEAR : OP_DOWN;
        dirUpNext = 1'b0;
      end else if (!dirUp) begin
        ctl.op    = OP_DOWN;
        dirUpNext = floorHit;
      end else begin
        ctl.op    = OP_UP;
        dirUpNext = !zeroHit;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dirUp <= 1'b0;
    else dirUp <= dirUpNext;
  end
endmodule

// File: rtl/ssm_dp.sv
module ssm_dp
  import ssm_pkg::*;
#(
  parameter int OFS_W = 8,
  parameter int LIMIT = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  stepCtl_t                ctl,
  input  logic [3:0]              upStep,
  input  logic [3:0]              downCode,
  output logic signed [OFS_W-1:0] offset,
  output logic                    stepStrobe,
  output logic                    floorHit,
  output logic                    zeroHit,
  output logic                    atFloor
);
  localparam int CW = OFS_W + 2;
  localparam logic signed [CW-1:0] FLOOR = -CW'(LIMIT);

  logic [3:0]             downMag;
  logic signed [CW-1:0]   curW;
  logic signed [CW-1:0]   downW;
  logic signed [CW-1:0]   upW;
  logic signed [CW-1:0]   candDown;
  logic signed [CW-1:0]   candUp;
  logic signed [CW-1:0]   nextW;

  assign downMag = 4'd0 - downCode;
  assign curW    = CW'(offset);
  assign downW   = $signed({{(CW-4){1'b0}}, downMag});
  assign upW     = $signed({{(CW-4){1'b0}}, upStep});

  always_comb begin
    candDown = curW - downW;
    if (candDown < FLOOR) candDown = FLOOR;
    candUp = curW + upW;
    if (candUp > 0) candUp = '0;
  end

  assign floorHit = (candDown == FLOOR);
  assign zeroHit  = (candUp == '0);
  assign atFloor  = (curW == FLOOR);

  always_comb begin
    unique case (ctl.op)
      OP_DOWN:  nextW = candDown;
      OP_UP:    nextW = candUp;
      OP_CLEAR: nextW = '0;
      default:  nextW = curW;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offset     <= '0;
      stepStrobe <= 1'b0;
    end else begin
      stepStrobe <= ctl.apply && (nextW != curW);
      if (ctl.apply) offset <= nextW[OFS_W-1:0];
    end
  end
endmodule

// File: rtl/ssm_profile_gen.sv
module ssm_profile_gen
  import ssm_pkg::*;
#(
  parameter int OFS_W    = 8,
  parameter int LIMIT    = 16,
  parameter int PRESCALE = 4,
  parameter int DWELL_W  = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    enable,
  input  logic                    pendulum,
  input  logic [3:0]              upStep,
  input  logic [3:0]              downCode,
  input  logic [DWELL_W-1:0]      dwellUnits,
  output logic signed [OFS_W-1:0] offset,
  output logic                    stepStrobe
);
  stepCtl_t ctl;
  logic     floorHit;
  logic     zeroHit;
  logic     atFloor;

  ssm_ctrl #(.PRESCALE(PRESCALE), .DWELL_W(DWELL_W)) uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .pendulum(pendulum),
    .dwellUnits(dwellUnits), .floorHit(floorHit), .zeroHit(zeroHit),
    .atFloor(atFloor), .ctl(ctl)
  );

  ssm_dp #(.OFS_W(OFS_W), .LIMIT(LIMIT)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .upStep(upStep), .downCode(downCode),
    .offset(offset), .stepStrobe(stepStrobe), .floorHit(floorHit),
    .zeroHit(zeroHit), .atFloor(atFloor)
  );
endmodule

// File: rtl/ssm_profile_chk.sv
module ssm_profile_chk #(
  parameter int OFS_W = 8,
  parameter int LIMIT = 16
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    enable,
  input logic                    pendulum,
  input logic signed [OFS_W-1:0] offset,
  input logic                    stepStrobe
);
  assert_in_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    (offset <= 0) && (offset >= -LIMIT));

  assert_strobe_on_change_R8: assert property (@(posedge clk) disable iff (!rstN)
    (offset != $past(offset)) |-> stepStrobe);

  assert_strobe_only_on_change_R8: assert property (@(posedge clk) disable iff (!rstN)
    stepStrobe |-> (offset != $past(offset)));

  assert_disable_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stepStrobe && !$past(enable)) |-> (offset == 0));

  assert_sawtooth_rise_to_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stepStrobe && $past(enable) && !$past(pendulum) && (offset > $past(offset)))
      |-> (offset == 0));
endmodule

bind ssm_profile_gen ssm_profile_chk #(.OFS_W(OFS_W), .LIMIT(LIMIT)) uChk (
  .clk(clk), .rstN(rstN), .enable(enable), .pendulum(pendulum),
  .offset(offset), .stepStrobe(stepStrobe)
);

// File: tb/sim_ssm_profile_gen.sv
module sim_ssm_profile_gen;
  localparam int LIM = 16;
  localparam int PRE = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic pendulum = 1'b1;
  logic [3:0] upStep = 4'd0;
  logic [3:0] downCode = 4'd0;
  logic [5:0] dwellUnits = 6'd0;
  logic signed [7:0] offset;
  logic stepStrobe;

  int tests = 0;
  int fails = 0;
  int cycle = 0;
  string phase = "R1";

  // behavioural reference state
  int mPre = 0, mDwell = 0, mOff = 0;
  bit mUp = 0, mStb = 0;
  int minSeen = 0, lastStb = -1, gap = -1;
  bit sawRise = 0;

  always #2 clk = ~clk;

  ssm_profile_gen u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .pendulum(pendulum),
    .upStep(upStep), .downCode(downCode), .dwellUnits(dwellUnits),
    .offset(offset), .stepStrobe(stepStrobe)
  );

  function automatic int magOf(input logic [3:0] c);
    return (16 - int'(c)) % 16;
  endfunction

  always @(posedge clk) begin
    cycle++;
    if (!rstN) begin
      mPre = 0; mDwell = 0; mOff = 0; mUp = 0; mStb = 0;
    end else begin
      bit tk, bnd;
      int nv;
      tk = (mPre == PRE - 1);
      mPre = (mPre + 1) % PRE;
      bnd = tk && (mDwell >= int'(dwellUnits));
      if (tk) mDwell = bnd ? 0 : mDwell + 1;
      mStb = 0;
      if (bnd) begin
        nv = mOff;
        if (!enable) begin
          nv = 0; mUp = 0;
        end else if (!pendulum) begin
          mUp = 0;
          if (mOff == -LIM) nv = 0;
          else nv = (mOff - magOf(downCode) < -LIM) ? -LIM : mOff - magOf(downCode);
        end else if (!mUp) begin
          nv = (mOff - magOf(downCode) < -LIM) ? -LIM : mOff - magOf(downCode);
          if (nv == -LIM) mUp = 1;
        end else begin
          nv = (mOff + int'(upStep) > 0) ? 0 : mOff + int'(upStep);
          if (nv == 0) mUp = 0;
        end
        mStb = (nv != mOff);
        mOff = nv;
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp, input string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      check(phase, int'(offset), mOff, "offset");
      check(phase, int'(stepStrobe), int'(mStb), "stepStrobe");
      if (int'(offset) > 0 || int'(offset) < -LIM) check("R6", int'(offset), 0, "range");
      if (int'(offset) < minSeen) minSeen = int'(offset);
      if (stepStrobe) begin
        if (lastStb >= 0) gap = cycle - lastStb;
        lastStb = cycle;
      end
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #20000000;
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    run(5);
    // R1: reset values
    check("R1", int'(offset), 0, "offset in reset");
    check("R1", int'(stepStrobe), 0, "strobe in reset");
    rstN = 1'b1;
    run(3);
    check("R1", int'(offset), 0, "offset after reset");

    // R4: pendulum, down 1, up 3
    phase = "R4";
    enable = 1; pendulum = 1; upStep = 4'd3; downCode = 4'b1111; dwellUnits = 0;
    minSeen = 0;
    run(60);
    begin
      int prev = int'(offset);
      run(60);
      if (int'(offset) > prev) sawRise = 1;
    end
    run(200);
    check("R4", minSeen, -LIM, "deepest offset");

    // R3: several down codes
    phase = "R3";
    downCode = 4'b1000; run(100);
    downCode = 4'b1001; run(100);
    downCode = 4'b0000; run(60);
    downCode = 4'b1110; run(100);

    // R2: dwell spacing
    phase = "R2";
    pendulum = 0; downCode = 4'b1111; dwellUnits = 6'd5;
    run(200);
    gap = -1;
    run(60);
    check("R2", gap, 6 * PRE, "strobe spacing");

    // R5: original saw-tooth
    phase = "R5";
    dwellUnits = 0; downCode = 4'b1110;
    run(400);

    // R9: up step has no effect in original shape
    phase = "R9";
    upStep = 4'd0; run(150);
    upStep = 4'd15; run(150);

    // R10: mode changes mid-sweep
    phase = "R10";
    pendulum = 1; upStep = 4'd2; downCode = 4'b1111;
    run(90);
    pendulum = 0; run(13);
    pendulum = 1; run(200);

    // R7: disable returns to zero
    phase = "R7";
    dwellUnits = 6'd3;
    enable = 0; run(40);
    check("R7", int'(offset), 0, "offset after disable");
    run(100);
    check("R7", int'(offset), 0, "offset held at zero");
    enable = 1; pendulum = 1; run(100);

    // R8: strobe stays low on unchanged boundaries (zero down step)
    phase = "R8";
    enable = 0; run(40);
    enable = 1; downCode = 4'b0000; dwellUnits = 0;
    lastStb = -1; run(80);
    check("R8", lastStb, -1, "strobe without change");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule